// File: doc/BRIEF.md
# Hertz and Percent Programmed PWM Generator with Pulse Accumulator

This block drives a single pulse-width-modulated output. Software gives it the output frequency in hertz and the duty cycle in whole percent, each as a 32-bit unsigned word. The block turns these into a period and a high time, counted in cycles of its own clock. The clock rate is the parameter `CLK_HZ`. While `enable` is high the output runs continuously. When `enable` falls the output returns low. A change to either setting is applied at the next period boundary with no ramping, so the output never carries a shortened pulse.

A 32-bit accumulator counts completed output periods and counts only upward. It is read as two 16-bit halves. Either half can be overwritten, and counting then continues from the written value. When the accumulator wraps past its all-ones value, a sticky flag is raised. Only reset clears that flag.

Top module: `pwm_hz_gen`

## Requirements
- R1: After reset, `pwmOut` is 0, the accumulator halves `accLo` and `accHi` are both 0, and `ovfFlag` is 0.
- R2: For a frequency f of at least 1, the period is P = CLK_HZ / f clock cycles, with the fraction dropped. The high time is H = P * d / 100, with the fraction dropped. `pwmOut` is 1 in the first H cycles of each period and 0 in the remaining P - H cycles.
- R3: A frequency above MAX_HZ (200000 by default) behaves exactly like MAX_HZ. A duty value above 100 behaves exactly like 100.
- R4: On the first clock edge at which `enable` is sampled high while the block is idle, a period starts, so `pwmOut` equals (H > 0) in the following cycle. On the first edge at which `enable` is sampled low, `pwmOut` goes to 0, and the unfinished period is not counted.
- R5: `freqHz` and `dutyPct` are captured only when a period starts. A change in the middle of a period leaves that period's high time unchanged, and the new values apply from the next period.
- R6: The accumulator adds exactly 1 at the edge that ends each full period. This includes periods with duty 0 and periods with duty 100. It never decreases except by a write or by wrapping.
- R7: A frequency of 0 holds `pwmOut` at 0 and adds nothing to the accumulator, for as long as `enable` stays high.
- R8: `accWrLo` replaces bits 15:0 of the accumulator, and `accWrHi` replaces bits 31:16, each with `accWrData` in the cycle after the edge. On an edge where a write and the end of a period coincide, the write wins and that period is not counted. Later periods count up from the written value.
- R9: An increment from 32'hFFFFFFFF gives 0 and sets `ovfFlag`. `ovfFlag` then stays 1 until reset, whatever is written.
- R10: `accLo` always shows accumulator bits 15:0, and `accHi` always shows bits 31:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, at CLK_HZ |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the output while high |
| freqHz | input | 32 | Requested output frequency in Hz |
| dutyPct | input | 32 | Requested duty cycle in percent |
| accWrLo | input | 1 | Write strobe for the low half of the accumulator |
| accWrHi | input | 1 | Write strobe for the high half of the accumulator |
| accWrData | input | 16 | Data for an accumulator half write |
| accLo | output | 16 | Accumulator bits 15:0 |
| accHi | output | 16 | Accumulator bits 31:16 |
| ovfFlag | output | 1 | Sticky accumulator wrap flag |
| pwmOut | output | 1 | PWM output |

## Verification
The assertions assume that `enable` is held low during reset, so the output is already idle on the first edge after reset. They also assume that the accumulator write strobes are single-cycle pulses whose data is stable at the sampling edge. The bench changes every input just after a falling edge and starts from reset with `enable` low, so it keeps within both assumptions. Frequencies in the random phase stay between 20 kHz and twice the clamp limit, which keeps every period at 100 cycles or fewer. It also picks some zero frequencies and some duty values above 100, so both clamps are exercised.

// File: rtl/pwm_hz_pkg.sv
package pwm_hz_pkg;
  // Strobes from the control FSM to the datapath; at most one of
  // clear/load/advance is active, pulseDone rides with a load.
  typedef struct packed {
    logic clear;
    logic load;
    logic advance;
    logic pulseDone;
  } pwmStrobe_t;
endpackage

// File: rtl/pwm_hz_ctrl.sv
module pwm_hz_ctrl
  import pwm_hz_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       atEnd,
  input  logic       zeroPeriod,
  output pwmStrobe_t stb
);
  logic running;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) running <= 1'b0;
    else       running <= enable;
  end

  // Period boundaries: idle->run, end of a full period, or a zero
  // period that is re-evaluated every cycle until a frequency arrives.
  always_comb begin
    stb = '0;
    if (!enable) begin
      stb.clear = 1'b1;
    end else if (!running || zeroPeriod) begin
      stb.load = 1'b1;
    end else if (atEnd) begin
      stb.load      = 1'b1;
      stb.pulseDone = 1'b1;
    end else begin
      stb.advance = 1'b1;
    end
  end
endmodule

// File: rtl/pwm_hz_datapath.sv
module pwm_hz_datapath
  import pwm_hz_pkg::*;
#(
  parameter int CLK_HZ = 2_000_000,
  parameter int MAX_HZ = 200_000,
  parameter int DATA_W = 32,
  parameter int PER_W  = 21
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] freqHz,
  input  logic [DATA_W-1:0] dutyPct,
  input  pwmStrobe_t        stb,
  output logic              atEnd,
  output logic              zeroPeriod,
  output logic              pwmOut
);
  localparam int PCT_W  = 7;
  localparam int PROD_W = PER_W + PCT_W;
  localparam logic [DATA_W-1:0] CLK_V  = DATA_W'(CLK_HZ);
  localparam logic [DATA_W-1:0] MAX_V  = DATA_W'(MAX_HZ);
  localparam logic [DATA_W-1:0] FULL_V = DATA_W'(100);

  logic [DATA_W-1:0] freqEff;
  logic [PCT_W-1:0]  dutyEff;
  logic [PER_W-1:0]  periodNew, highNew;
  logic [PROD_W-1:0] prod;
  logic [PER_W-1:0]  cnt, curPeriod, curHigh;

  // Clamp the requests, then derive period and high time in cycles.
  always_comb begin
    freqEff   = (freqHz > MAX_V) ? MAX_V : freqHz;
    dutyEff   = (dutyPct > FULL_V) ? PCT_W'(100) : dutyPct[PCT_W-1:0];
    periodNew = (freqEff == '0) ? '0 : PER_W'(CLK_V / freqEff);
    prod      = PROD_W'(periodNew) * PROD_W'(dutyEff);
    highNew   = PER_W'(prod / PROD_W'(100));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt       <= '0;
      curPeriod <= '0;
      curHigh   <= '0;
    end else if (stb.clear) begin
      cnt       <= '0;
      curPeriod <= '0;
      curHigh   <= '0;
    end else if (stb.load) begin
      cnt       <= '0;
      curPeriod <= periodNew;
      curHigh   <= highNew;
    end else if (stb.advance) begin
      cnt <= cnt + PER_W'(1);
    end
  end

  assign zeroPeriod = (curPeriod == '0);
  assign atEnd      = (cnt == curPeriod - PER_W'(1));
  assign pwmOut     = (cnt < curHigh);
endmodule

// File: rtl/pwm_hz_accum.sv
module pwm_hz_accum #(
  parameter int ACC_W  = 32,
  parameter int HALF_W = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [ACC_W/HALF_W-1:0]     wrHalf,
  input  logic [HALF_W-1:0]           wrData,
  input  logic                        pulseDone,
  output logic [ACC_W-1:0]            acc,
  output logic                        ovf
);
  localparam int NUM_HALF = ACC_W / HALF_W;

  logic [ACC_W-1:0] accNext;
  logic             wrapNow;

  always_comb begin
    accNext = acc;
    wrapNow = 1'b0;
    if (|wrHalf) begin
      for (int h = 0; h < NUM_HALF; h++) begin
        if (wrHalf[h]) accNext[h*HALF_W +: HALF_W] = wrData;
      end
    end else if (pulseDone) begin
      accNext = acc + ACC_W'(1);
      wrapNow = &acc;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc <= '0;
      ovf <= 1'b0;
    end else begin
      acc <= accNext;
      if (wrapNow) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/pwm_hz_gen.sv
module pwm_hz_gen
  import pwm_hz_pkg::*;
#(
  parameter int CLK_HZ = 2_000_000,
  parameter int MAX_HZ = 200_000,
  parameter int DATA_W = 32,
  parameter int ACC_W  = 32,
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [DATA_W-1:0] freqHz,
  input  logic [DATA_W-1:0] dutyPct,
  input  logic              accWrLo,
  input  logic              accWrHi,
  input  logic [HALF_W-1:0] accWrData,
  output logic [HALF_W-1:0] accLo,
  output logic [HALF_W-1:0] accHi,
  output logic              ovfFlag,
  output logic              pwmOut
);
  localparam int PER_W = $clog2(CLK_HZ + 1);

  pwmStrobe_t       stb;
  logic             atEnd, zeroPeriod;
  logic [ACC_W-1:0] acc;

  pwm_hz_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable),
    .atEnd(atEnd), .zeroPeriod(zeroPeriod), .stb(stb)
  );

  pwm_hz_datapath #(
    .CLK_HZ(CLK_HZ), .MAX_HZ(MAX_HZ), .DATA_W(DATA_W), .PER_W(PER_W)
  ) uPath (
    .clk(clk), .rstN(rstN), .freqHz(freqHz), .dutyPct(dutyPct),
    .stb(stb), .atEnd(atEnd), .zeroPeriod(zeroPeriod), .pwmOut(pwmOut)
  );

  pwm_hz_accum #(.ACC_W(ACC_W), .HALF_W(HALF_W)) uAcc (
    .clk(clk), .rstN(rstN), .wrHalf({accWrHi, accWrLo}),
    .wrData(accWrData), .pulseDone(stb.pulseDone), .acc(acc), .ovf(ovfFlag)
  );

  assign accLo = acc[HALF_W-1:0];
  assign accHi = acc[ACC_W-1:HALF_W];
endmodule

// File: rtl/pwm_hz_checker.sv
module pwm_hz_checker
  import pwm_hz_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              accWrLo,
  input logic              accWrHi,
  input logic [HALF_W-1:0] accWrData,
  input logic [HALF_W-1:0] accLo,
  input logic [HALF_W-1:0] accHi,
  input logic              ovfFlag,
  input logic              pwmOut,
  input pwmStrobe_t        stb
);
  logic [2*HALF_W-1:0] accAll;
  logic                noWr;
  assign accAll = {accHi, accLo};
  assign noWr   = !accWrLo && !accWrHi;

  a_r4_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !$past(enable) |-> !pwmOut);

  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.clear, stb.load, stb.advance}));

  a_r6_step: assert property (@(posedge clk) disable iff (!rstN)
    noWr |=> (accAll == $past(accAll) || accAll == $past(accAll) + 1'b1));

  a_r6_count_only_at_end: assert property (@(posedge clk) disable iff (!rstN)
    (noWr && !stb.pulseDone) |=> $stable(accAll));

  a_r8_write_lo: assert property (@(posedge clk) disable iff (!rstN)
    accWrLo |=> accLo == $past(accWrData));

  a_r8_write_hi: assert property (@(posedge clk) disable iff (!rstN)
    accWrHi |=> accHi == $past(accWrData));

  a_r9_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (noWr && (&accAll)) |=> ((&accAll) || (accAll == '0 && ovfFlag)));

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ovfFlag |=> ovfFlag);
endmodule

bind pwm_hz_gen pwm_hz_checker #(.HALF_W(HALF_W)) uChk (
  .clk(clk), .rstN(rstN), .enable(enable), .accWrLo(accWrLo),
  .accWrHi(accWrHi), .accWrData(accWrData), .accLo(accLo), .accHi(accHi),
  .ovfFlag(ovfFlag), .pwmOut(pwmOut), .stb(stb)
);

// File: tb/tb_pwm_hz_gen.sv
module tb_pwm_hz_gen;
  localparam int CLK_PERIOD = 10;
  localparam longint CLK_HZ = 2_000_000;
  localparam longint MAX_HZ = 200_000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [31:0] freqHz = '0;
  logic [31:0] dutyPct = '0;
  logic        accWrLo = 1'b0;
  logic        accWrHi = 1'b0;
  logic [15:0] accWrData = '0;
  logic [15:0] accLo, accHi;
  logic        ovfFlag, pwmOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  pwm_hz_gen dut (
    .clk(clk), .rstN(rstN), .enable(enable), .freqHz(freqHz),
    .dutyPct(dutyPct), .accWrLo(accWrLo), .accWrHi(accWrHi),
    .accWrData(accWrData), .accLo(accLo), .accHi(accHi),
    .ovfFlag(ovfFlag), .pwmOut(pwmOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference: period bookkeeping in plain integers.
  bit          mRun = 0;
  longint      mCnt = 0, mPer = 0, mHigh = 0;
  longint      mAcc = 0;
  bit          mOvf = 0;

  always @(posedge clk) begin
    bit done;
    longint f, d;
    done = 0;
    if (!rstN) begin
      mRun = 0; mCnt = 0; mPer = 0; mHigh = 0; mAcc = 0; mOvf = 0;
    end else begin
      if (!enable) begin
        mRun = 0; mCnt = 0; mPer = 0; mHigh = 0;
      end else if (!mRun || mPer == 0 || mCnt == mPer - 1) begin
        done = mRun && (mPer != 0);
        f = (longint'(freqHz) > MAX_HZ) ? MAX_HZ : longint'(freqHz);
        d = (longint'(dutyPct) > 100) ? 100 : longint'(dutyPct);
        mPer  = (f == 0) ? 0 : CLK_HZ / f;
        mHigh = mPer * d / 100;
        mCnt  = 0;
        mRun  = 1;
      end else begin
        mCnt++;
      end
      if (accWrLo || accWrHi) begin
        if (accWrLo) mAcc = (mAcc & 64'hFFFF0000) | longint'(accWrData);
        if (accWrHi) mAcc = (mAcc & 64'h0000FFFF) | (longint'(accWrData) << 16);
      end else if (done) begin
        if (mAcc == 64'hFFFFFFFF) mOvf = 1;
        mAcc = (mAcc + 1) & 64'hFFFFFFFF;
      end
    end
  end

  // Every-cycle comparison against the reference.
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk("R2 pwmOut vs model", longint'(pwmOut), longint'(mCnt < mHigh));
      chk("R6 R8 accumulator vs model", {accHi, accLo}, mAcc);
      chk("R9 ovfFlag vs model", longint'(ovfFlag), longint'(mOvf));
    end
  end

  task automatic countHigh(input int n, output int hc);
    hc = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hc += int'(pwmOut);
    end
  endtask

  task automatic writeHalf(input bit hi, input logic [15:0] data);
    accWrData = data;
    accWrLo = !hi;
    accWrHi = hi;
    @(negedge clk);
    accWrLo = 1'b0;
    accWrHi = 1'b0;
  endtask

  task automatic startRun(input logic [31:0] f, input logic [31:0] d);
    enable = 1'b0;
    @(negedge clk);
    freqHz = f;
    dutyPct = d;
    enable = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int hc;
    longint a0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 pwmOut after reset", pwmOut, 0);
    chk("R1 accLo after reset", accLo, 0);
    chk("R1 accHi after reset", accHi, 0);
    chk("R1 ovfFlag after reset", ovfFlag, 0);

    // R4: start, first cycle high; R2: 20 kHz -> 100 cycles, 30 high.
    startRun(20000, 30);
    @(negedge clk);
    chk("R4 output high first cycle after enable", pwmOut, 1);
    countHigh(99, hc);
    chk("R2 high cycles per period", hc + 1, 30);
    @(negedge clk);
    chk("R6 one pulse per period", {accHi, accLo}, 1);

    // R5: mid-period duty change applies from next period.
    startRun(20000, 30);
    countHigh(10, hc);
    dutyPct = 70;
    countHigh(90, hc);
    chk("R5 old duty kept to period end", hc, 20);
    countHigh(100, hc);
    chk("R5 new duty in next period", hc, 70);

    // R4: disable mid-period, output low, partial not counted.
    countHigh(40, hc);
    a0 = {accHi, accLo};
    enable = 1'b0;
    @(negedge clk);
    chk("R4 output low after disable", pwmOut, 0);
    chk("R4 partial period not counted", {accHi, accLo}, a0);

    // R3: 1 MHz clamps to 200 kHz (10 cycles); duty 150 -> 100.
    startRun(1_000_000, 150);
    countHigh(20, hc);
    chk("R3 clamped duty fully high", hc, 20);
    startRun(200_000, 50);
    countHigh(20, hc);
    chk("R3 clamp limit 200 kHz half duty", hc, 10);

    // R6: duty 0 and 100 still count.
    startRun(20000, 0);
    a0 = {accHi, accLo};
    countHigh(300, hc);
    @(negedge clk);
    chk("R6 duty 0 output low", hc, 0);
    chk("R6 duty 0 counts periods", {accHi, accLo} - a0, 3);
    startRun(20000, 100);
    a0 = {accHi, accLo};
    countHigh(300, hc);
    @(negedge clk);
    chk("R6 duty 100 output high", hc, 300);
    chk("R6 duty 100 counts periods", {accHi, accLo} - a0, 3);

    // R7: zero frequency holds low, no counting.
    startRun(0, 50);
    a0 = {accHi, accLo};
    countHigh(50, hc);
    chk("R7 zero freq output low", hc, 0);
    chk("R7 zero freq no count", {accHi, accLo}, a0);

    // R8/R10: half writes.
    enable = 1'b0;
    @(negedge clk);
    writeHalf(0, 16'h1234);
    writeHalf(1, 16'hABCD);
    chk("R8 R10 low half written", accLo, 16'h1234);
    chk("R8 R10 high half written", accHi, 16'hABCD);

    // R9: wrap from all ones.
    writeHalf(1, 16'hFFFF);
    writeHalf(0, 16'hFFFF);
    chk("R9 flag clear before wrap", ovfFlag, 0);
    startRun(200_000, 50);
    countHigh(10, hc);
    @(negedge clk);
    chk("R9 accumulator wraps to zero", {accHi, accLo}, 0);
    chk("R9 flag set on wrap", ovfFlag, 1);
    enable = 1'b0;
    @(negedge clk);
    writeHalf(0, 16'h0005);
    chk("R9 flag sticky after write", ovfFlag, 1);
    chk("R10 low half after write", accLo, 5);
    chk("R8 count continues from written value", accHi, 0);

    // Random phase, model compared every cycle (R2 R3 R5 R6 R8).
    for (int i = 0; i < 60; i++) begin
      freqHz  = (i % 7 == 0) ? 32'd0 : $urandom_range(400000, 20000);
      dutyPct = $urandom_range(130, 0);
      if (i % 9 == 4) enable = 1'b0; else enable = 1'b1;
      for (int k = 0; k < int'($urandom_range(150, 1)); k++) begin
        @(negedge clk);
        if ($urandom_range(40, 0) == 0) writeHalf($urandom_range(1, 0) == 1, 16'($urandom()));
      end
    end
    @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule